// File: doc/BRIEF.md
# Serial Target Front End with Clock-Idle Mode Detection

This block sits between the pins of a serial flash-style target and the command logic of its core. It oversamples the select, serial clock and serial data-in pins on the system clock, frames each transaction between a falling and a rising edge of the active-low select, and turns the incoming bit stream into whole bytes. Each byte is handed to the core with a valid strobe, and the first byte of a frame is marked. When select rises, the core receives an end-of-frame strobe.

Serial clock polarity is chosen again for every transaction. At each select falling edge the block samples the idle clock level: a high level selects mode 3 and a low level selects mode 0. In both modes input bits are taken on rising serial-clock edges, and response bits change on falling edges. The core offers response bytes on a byte/valid pair and sees a take strobe when a byte is consumed. The serial data-out pin is enabled only inside a frame. An active-low reset aborts any transfer, and the block returns to mode 3.

Top module: `spi_target_frontend`

## Requirements
- R1: Data-in bits are captured on rising serial-clock edges inside a frame, most significant bit first. Every eighth captured bit produces a one-cycle `rxValid` with the assembled byte on `rxByte`.
- R2: While select is high, serial clock and data-in activity produces no byte strobes, and `spiDoutEn` is 0 with `spiDout` at 0.
- R3: A frame begins only on a high-to-low select transition and ends on the next low-to-high transition. The end produces exactly one `rxEnd` pulse.
- R4: At each select falling edge, `clkIdleHigh` takes the sampled serial-clock level: 1 means mode 3 and 0 means mode 0. It holds that value until the next select falling edge.
- R5: During and after reset, `clkIdleHigh` is 1, `spiDoutEn` is 0 and no strobes are raised. If select is already low when reset is released, nothing is accepted until select has gone high and fallen again.
- R6: Driving `rstN` low in the middle of a frame ends the frame at once: the output is disabled and no further bytes are delivered while reset is held.
- R7: `rxFirst` is raised together with `rxValid` for the first complete byte of a frame and for no other byte.
- R8: Response bytes leave on `spiDout` most significant bit first and change only on falling serial-clock edges. In mode 0 the first byte is loaded at the select falling edge. In mode 3 it is loaded at the first falling edge. Each following byte is loaded at the falling edge that comes after every eighth rising edge. A load pulses `txTake` when `txValid` is 1, and it shifts out 0x00 when `txValid` is 0.
- R9: When select rises partway through a byte, the partial bits are dropped: no `rxValid` is raised for them, and `rxEnd` is still pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSelN | input | 1 | Active-low target select pin |
| spiClk | input | 1 | Serial clock pin |
| spiDin | input | 1 | Serial data-in pin |
| spiDout | output | 1 | Serial data-out value |
| spiDoutEn | output | 1 | Output enable for the data-out driver (0 = high impedance) |
| clkIdleHigh | output | 1 | Detected mode: 1 = mode 3, 0 = mode 0 |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe: `rxByte` holds a new byte |
| rxFirst | output | 1 | Marks the first byte of a frame |
| rxEnd | output | 1 | One-cycle strobe at the end of a frame |
| txByte | input | 8 | Next response byte offered by the core |
| txValid | input | 1 | `txByte` is available |
| txTake | output | 1 | One-cycle strobe: `txByte` was loaded |

## Verification
Assertions check on every cycle that the detected mode changes only at a select falling edge, that a frame opens only on such an edge, that the frame is closed two samples after select rises, and that the byte, first-byte, end and take strobes each follow the control event that produced them. Only the bench's scenarios can show the bit order and values of the bytes in both directions across full 256-value sweeps in each mode, the difference in first-byte load timing between mode 0 and mode 3, the zero fill when no byte is offered, the dropping of partial bytes, and the need for a fresh select edge after reset.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  // Control events handed from the frame controller to the shift datapath.
  typedef struct packed {
    logic startFrame; // select fell: new frame
    logic preload;    // select fell with clock idle low (mode 0): load tx now
    logic capture;    // rising serial-clock edge inside a frame
    logic launch;     // falling serial-clock edge inside a frame
    logic endFrame;   // select rose while a frame was open
  } feStrobes_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : gBit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn[g]};
      end
      assign syncOut[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selSync,
  input  logic       clkSync,
  output feStrobes_t strobes,
  output logic       frameActive,
  output logic       idleHigh
);
  logic selPrev, clkPrev;
  logic selFall, selRise, clkRise, clkFall;

  always_comb begin
    selFall = selPrev & ~selSync;
    selRise = ~selPrev & selSync;
    clkRise = ~clkPrev & clkSync;
    clkFall = clkPrev & ~clkSync;
    strobes.startFrame = selFall;
    strobes.preload    = selFall & ~clkSync;
    strobes.capture    = frameActive & ~selSync & clkRise;
    strobes.launch     = frameActive & ~selSync & clkFall;
    strobes.endFrame   = frameActive & selRise;
  end

  // Synchronizers reset to 0, so a select held low through reset
  // never looks like a falling edge: a fresh edge is required.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev     <= 1'b0;
      clkPrev     <= 1'b0;
      frameActive <= 1'b0;
      idleHigh    <= 1'b1;
    end else begin
      selPrev <= selSync;
      clkPrev <= clkSync;
      if (selFall) begin
        frameActive <= 1'b1;
        idleHigh    <= clkSync;
      end else if (selRise) begin
        frameActive <= 1'b0;
      end
    end
  end

  assert_open_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameActive) |-> $past(selPrev && !selSync));

  assert_mode_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idleHigh) |-> $past(selFall));

  assert_closed_when_deselected_R2: assert property (@(posedge clk) disable iff (!rstN)
    (selSync && selPrev) |-> !frameActive);
endmodule

// File: rtl/spi_fe_dp.sv
module spi_fe_dp
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  feStrobes_t        strobes,
  input  logic              dinSync,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              txValid,
  output logic              txMsb,
  output logic              txTake,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              rxFirst,
  output logic              rxEnd
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic              firstPending;
  logic [BYTE_W-1:0] loadVal;

  assign loadVal = txValid ? txByte : '0;
  assign txMsb   = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt       <= '0;
      rxShift      <= '0;
      txShift      <= '0;
      firstPending <= 1'b0;
      rxByte       <= '0;
      rxValid      <= 1'b0;
      rxFirst      <= 1'b0;
      rxEnd        <= 1'b0;
      txTake       <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      rxFirst <= 1'b0;
      rxEnd   <= 1'b0;
      txTake  <= 1'b0;
      if (strobes.startFrame) begin
        bitCnt       <= '0;
        rxShift      <= '0;
        firstPending <= 1'b1;
        if (strobes.preload) begin
          txShift <= loadVal;
          txTake  <= txValid;
        end else begin
          txShift <= '0;
        end
      end else begin
        if (strobes.capture) begin
          rxShift <= {rxShift[BYTE_W-2:0], dinSync};
          if (bitCnt == LAST_BIT) begin
            bitCnt       <= '0;
            rxByte       <= {rxShift[BYTE_W-2:0], dinSync};
            rxValid      <= 1'b1;
            rxFirst      <= firstPending;
            firstPending <= 1'b0;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        if (strobes.launch) begin
          if (bitCnt == '0) begin
            txShift <= loadVal;
            txTake  <= txValid;
          end else begin
            txShift <= {txShift[BYTE_W-2:0], 1'b0};
          end
        end
        if (strobes.endFrame) begin
          rxEnd  <= 1'b1;
          bitCnt <= '0;
        end
      end
    end
  end

  assert_byte_after_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(strobes.capture));

  assert_first_with_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxFirst |-> rxValid);

  assert_take_on_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> $past((strobes.preload || strobes.launch) && txValid));

  assert_end_after_close_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxEnd |-> ($past(strobes.endFrame) && !rxValid));
endmodule

// File: rtl/spi_target_frontend.sv
module spi_target_frontend
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSelN,
  input  logic              spiClk,
  input  logic              spiDin,
  output logic              spiDout,
  output logic              spiDoutEn,
  output logic              clkIdleHigh,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              rxFirst,
  output logic              rxEnd,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              txValid,
  output logic              txTake
);
  logic [2:0] pinSync;
  feStrobes_t strobes;
  logic       frameActive;
  logic       txMsb;

  spi_fe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({spiSelN, spiClk, spiDin}),
    .syncOut(pinSync)
  );

  spi_fe_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .selSync(pinSync[2]), .clkSync(pinSync[1]),
    .strobes(strobes), .frameActive(frameActive), .idleHigh(clkIdleHigh)
  );

  spi_fe_dp #(.BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dinSync(pinSync[0]),
    .txByte(txByte), .txValid(txValid), .txMsb(txMsb), .txTake(txTake),
    .rxByte(rxByte), .rxValid(rxValid), .rxFirst(rxFirst), .rxEnd(rxEnd)
  );

  assign spiDoutEn = frameActive;
  assign spiDout   = frameActive & txMsb;
endmodule

// File: tb/test_spi_target_frontend.sv
module test_spi_target_frontend;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiSelN = 1'b1, spiClk = 1'b1, spiDin = 1'b0;
  logic       spiDout, spiDoutEn, clkIdleHigh;
  logic [7:0] rxByte;
  logic       rxValid, rxFirst, rxEnd, txValid = 1'b1, txTake;
  logic [7:0] txByte;

  int checks = 0, errors = 0;
  int txIdx = 0;
  int rxCount = 0, firstCount = 0, firstAt = -1, endCount = 0;
  logic [7:0] rxLog [0:1023];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] txPat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  assign txByte = txPat(txIdx);

  spi_target_frontend i_spi_target_frontend (
    .clk(clk), .rstN(rstN), .spiSelN(spiSelN), .spiClk(spiClk), .spiDin(spiDin),
    .spiDout(spiDout), .spiDoutEn(spiDoutEn), .clkIdleHigh(clkIdleHigh),
    .rxByte(rxByte), .rxValid(rxValid), .rxFirst(rxFirst), .rxEnd(rxEnd),
    .txByte(txByte), .txValid(txValid), .txTake(txTake)
  );

  always @(posedge clk) begin
    if (txTake) txIdx <= txIdx + 1;
    if (rxValid) begin
      rxLog[rxCount & 1023] <= rxByte;
      rxCount <= rxCount + 1;
      if (rxFirst) begin
        firstCount <= firstCount + 1;
        firstAt <= rxCount;
      end
    end
    if (rxEnd) endCount <= endCount + 1;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic halfBit();
    repeat (8) @(negedge clk);
  endtask

  // One frame: nBytes whole bytes (value (i+seed)&255) then extraBits partial bits.
  task automatic frame(input bit m3, input int nBytes, input int extraBits, input int seed);
    int rxBase, firstBase, endBase, txStart, oeBad;
    logic [7:0] got, dat;
    rxBase = rxCount; firstBase = firstCount; endBase = endCount;
    oeBad = 0;
    spiClk = m3;
    halfBit();
    txStart = txIdx;
    spiSelN = 1'b0;
    halfBit(); halfBit();
    chk(clkIdleHigh == m3, "R4 mode detected at select fall", clkIdleHigh, m3);
    for (int k = 0; k < nBytes + 1; k++) begin
      int nb;
      nb = (k < nBytes) ? 8 : extraBits;
      dat = 8'((k + seed) & 255);
      got = '0;
      for (int b = 7; b >= 8 - nb; b--) begin
        spiClk = 1'b0;
        spiDin = dat[b];
        halfBit();
        got[b] = spiDout;
        if (!spiDoutEn) oeBad++;
        spiClk = 1'b1;
        halfBit();
      end
      if (k < nBytes)
        chk(got == (txValid ? txPat(txStart + k) : 8'h00),
            "R8 response byte on data-out", got, txValid ? txPat(txStart + k) : 0);
    end
    chk(oeBad == 0, "R2 output enabled inside frame", oeBad, 0);
    if (!m3) begin
      spiClk = 1'b0;
      halfBit();
    end
    spiSelN = 1'b1;
    halfBit(); halfBit();
    chk(rxCount - rxBase == nBytes, "R1 R9 byte count per frame", rxCount - rxBase, nBytes);
    for (int k = 0; k < nBytes; k++)
      chk(rxLog[(rxBase + k) & 1023] == 8'((k + seed) & 255), "R1 received byte",
          rxLog[(rxBase + k) & 1023], (k + seed) & 255);
    if (nBytes > 0) begin
      chk(firstCount - firstBase == 1, "R7 one first-byte mark", firstCount - firstBase, 1);
      chk(firstAt == rxBase, "R7 mark on first byte", firstAt, rxBase);
    end
    chk(endCount - endBase == 1, "R3 R9 one end strobe", endCount - endBase, 1);
    chk(spiDoutEn == 1'b0, "R2 output disabled after frame", spiDoutEn, 0);
    chk(clkIdleHigh == m3, "R4 mode held after frame", clkIdleHigh, m3);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int base, oeBad;
    repeat (4) @(negedge clk);
    chk(spiDoutEn == 0, "R5 output disabled in reset", spiDoutEn, 0);
    chk(clkIdleHigh == 1, "R5 mode 3 in reset", clkIdleHigh, 1);
    chk(rxValid == 0 && rxEnd == 0 && txTake == 0, "R5 no strobes in reset", rxValid, 0);
    rstN = 1'b1;
    halfBit();

    // Full byte sweeps in both modes
    frame(1'b1, 256, 0, 0);
    frame(1'b0, 256, 0, 128);
    // Short frames with different patterns
    frame(1'b0, 3, 0, 250);
    frame(1'b1, 1, 0, 165);
    // No response offered: zero fill
    txValid = 1'b0;
    base = txIdx;
    frame(1'b1, 2, 0, 90);
    frame(1'b0, 2, 0, 17);
    chk(txIdx == base, "R8 no take without valid", txIdx, base);
    txValid = 1'b1;
    // Partial bytes dropped
    frame(1'b1, 1, 3, 60);
    frame(1'b0, 2, 7, 200);
    frame(1'b1, 0, 5, 0);

    // Deselected activity ignored
    base = rxCount; oeBad = 0;
    spiSelN = 1'b1;
    for (int i = 0; i < 16; i++) begin
      spiClk = 1'b0; spiDin = i[0]; halfBit();
      if (spiDoutEn) oeBad++;
      spiClk = 1'b1; halfBit();
    end
    chk(rxCount == base, "R2 no bytes while deselected", rxCount, base);
    chk(oeBad == 0, "R2 output off while deselected", oeBad, 0);

    // Reset in mid-frame (mode 0), select kept low through release
    spiClk = 1'b0; halfBit();
    spiSelN = 1'b0; halfBit();
    chk(clkIdleHigh == 0, "R4 mode 0 before reset", clkIdleHigh, 0);
    base = rxCount;
    for (int i = 0; i < 5; i++) begin
      spiClk = 1'b0; spiDin = 1'b1; halfBit();
      spiClk = 1'b1; halfBit();
    end
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(spiDoutEn == 0, "R6 output off during reset", spiDoutEn, 0);
    rstN = 1'b1;
    halfBit();
    chk(clkIdleHigh == 1, "R5 mode 3 after reset", clkIdleHigh, 1);
    oeBad = 0;
    for (int i = 0; i < 16; i++) begin
      spiClk = 1'b0; spiDin = i[1]; halfBit();
      if (spiDoutEn) oeBad++;
      spiClk = 1'b1; halfBit();
    end
    chk(rxCount == base, "R5 R6 nothing accepted without fresh fall", rxCount, base);
    chk(oeBad == 0, "R5 output off without fresh fall", oeBad, 0);
    spiSelN = 1'b1; halfBit();
    frame(1'b1, 2, 0, 33);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule